// File: doc/BRIEF.md
# PMP Control Register Bank

This block holds the physical memory protection configuration bytes and address registers for one hart, and serves machine-mode CSR reads and writes aimed at them. A CSR request carries a 12-bit CSR number, a write flag, write data and the requester's privilege. The response carries the old register value and an illegal-instruction flag. Every request falls into one of three classes. The register may be live, meaning it is backed by implemented entries. It may be visible but zero, meaning it reads zero and drops writes. Or it may be absent, in which case it can raise the illegal flag.

The number of implemented entries is a parameter from 0 to 64. The count that software sees is always rounded to 0, 16 or 64, so the decoder separates absent numbers from zero-reading ones and live ones. Writes are legalised as write-any/read-legal fields: reserved bits are cleared, reserved permission and mode combinations are folded to legal ones, and address bits finer than the granularity are masked on read. The per-entry configuration bytes and effective addresses leave the bank on flat output buses for the address checker.

The request side uses a valid/ready handshake, and so does the response side. A request is accepted when `req_valid` and `req_ready` are both high. Its response is registered and appears on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and `req_ready` is low, so no new request is taken.

Top module: `pmp_csr_bank`

## Requirements
- R1: `req_ready` is high exactly when no response is pending or the pending one is being taken. An accepted request gives `rsp_valid` on the next cycle. A response that is not taken holds its data and flag unchanged.
- R2: a request whose `req_priv` is not 2'b11 (machine) answers illegal with zero data and changes no register, whatever its target.
- R3: the visible count V is 0 when NUM_ENTRIES is 0, 16 when NUM_ENTRIES is 1 to 16, and 64 otherwise. Configuration CSR 0x3A0+c (c in 0..15) is visible when c < V/4. Address CSR 0x3B0+a (a in 0..63) is visible when a < V. Any other CSR number counts as absent.
- R4: an absent CSR answers illegal when TRAP_ABSENT is 1, and otherwise answers zero and not illegal. In both cases a write to it changes nothing.
- R5: a visible register whose entries all lie at or above NUM_ENTRIES reads zero, ignores writes and is never illegal from machine mode.
- R6: with XLEN 32, configuration CSR c holds entries 4c..4c+3. With XLEN 64, odd c is absent and even c holds entries 4c..4c+7. In both cases entry 4c+k sits at bits 8k+7:8k. Bytes of entries at or above NUM_ENTRIES read zero.
- R7: a configuration byte has R at bit 0, W at bit 1, X at bit 2, mode at bits 4:3 (0 off, 1 top-of-range, 2 four-byte naturally aligned, 3 naturally aligned power of two) and lock at bit 7. Bits 6:5 always read zero. W written without R is stored as zero. When GRAN > 2, mode 2 is stored as mode 0.
- R8: an address register reads back the written value, cut to 32 bits (XLEN 32) or 54 bits (XLEN 64). With G = GRAN-2, mode 3 with G >= 2 reads bits G-2:0 as ones, and any other mode with G >= 1 reads bits G-1:0 as zero. The stored bits are kept, so a later mode change alters what reads back.
- R9: a write request returns the value the register held before that write. The new value is seen by the next request.
- R10: after reset every entry holds RST_CFG and RST_ADDR (default zero). `pmp_cfg_o` and `pmp_addr_o` carry each implemented entry's byte and read-back address, with entry i in slice i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_csr | input | 12 | CSR number |
| req_wdata | input | XLEN | write data |
| req_priv | input | 2 | requester privilege, 2'b11 = machine |
| rsp_valid | output | 1 | response present |
| rsp_ready | input | 1 | consumer takes the response |
| rsp_rdata | output | XLEN | register value before the request |
| rsp_illegal | output | 1 | illegal-instruction flag |
| pmp_cfg_o | output | max(NUM_ENTRIES,1)*8 | per-entry configuration bytes |
| pmp_addr_o | output | max(NUM_ENTRIES,1)*AW | per-entry effective addresses (AW 32 or 54) |

## Verification
A request driven at a falling edge is accepted at the next rising edge. Its response is in the response register after that edge, so the bench reads `rsp_rdata` and `rsp_illegal` at the following falling edge, one cycle after driving. A write reaches the entry registers at the same rising edge, so `pmp_cfg_o` and `pmp_addr_o` are compared at that same falling edge, and a read-back issued afterwards sees the new state. For back-pressure, the bench holds `rsp_ready` low and checks on each later falling edge that the response and `req_ready` stay frozen until it is released.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmp_mode_e;

  typedef struct packed {
    logic      lock;
    logic [1:0] rsvd;
    pmp_mode_e mode;
    logic      x;
    logic      w;
    logic      r;
  } pmp_cfg_t;

  localparam logic [11:0] CFG_CSR_BASE  = 12'h3A0;
  localparam logic [11:0] ADDR_CSR_BASE = 12'h3B0;

  // Fold a raw byte onto the legal configuration encodings.
  function automatic logic [7:0] legalise_cfg(input logic [7:0] raw, input int gran);
    pmp_cfg_t c;
    c      = pmp_cfg_t'(raw);
    c.rsvd = 2'b00;
    if (c.w && !c.r) c.w = 1'b0;
    if (gran > 2 && c.mode == MODE_NA4) c.mode = MODE_OFF;
    return c;
  endfunction

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
  import pmp_bank_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16
) (
  input  logic [11:0] csr,
  output logic        is_cfg,
  output logic        is_addr,
  output logic [5:0]  idx,
  output logic        present
);
  // Visible register count is rounded up to 0, 16 or 64.
  localparam int VIS     = (NUM_ENTRIES == 0) ? 0 : ((NUM_ENTRIES <= 16) ? 16 : 64);
  localparam int CFG_VIS = VIS / 4;

  logic [11:0] off_c;
  logic [11:0] off_a;

  assign off_c = csr - CFG_CSR_BASE;
  assign off_a = csr - ADDR_CSR_BASE;

  always_comb begin
    is_cfg  = (csr >= CFG_CSR_BASE) && (csr < CFG_CSR_BASE + 12'd16);
    is_addr = (csr >= ADDR_CSR_BASE) && (csr < ADDR_CSR_BASE + 12'd64);
    idx     = '0;
    present = 1'b0;
    if (is_cfg) begin
      idx     = off_c[5:0];
      present = (int'(off_c) < CFG_VIS) && ((XLEN == 32) || !off_c[0]);
    end else if (is_addr) begin
      idx     = off_a[5:0];
      present = int'(off_a) < VIS;
    end
  end

endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_bank_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          GRAN     = 2,
  parameter logic [7:0]  RST_CFG  = 8'h00,
  parameter logic [63:0] RST_ADDR = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wd,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wd,
  output logic [7:0]        cfg_q,
  output logic [ADDR_W-1:0] addr_rd
);
  localparam int G       = GRAN - 2;
  localparam int SH_ONES = (G >= 2) ? G - 1 : 0;
  localparam int SH_ZERO = (G >= 1) ? G : 0;
  localparam logic [ADDR_W-1:0] ONES_MASK = ADDR_W'((64'd1 << SH_ONES) - 64'd1);
  localparam logic [ADDR_W-1:0] ZERO_MASK = ADDR_W'((64'd1 << SH_ZERO) - 64'd1);

  pmp_cfg_t          cfg_r;
  logic [ADDR_W-1:0] addr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r  <= pmp_cfg_t'(RST_CFG);
      addr_r <= ADDR_W'(RST_ADDR);
    end else begin
      if (cfg_we)  cfg_r  <= pmp_cfg_t'(legalise_cfg(cfg_wd, GRAN));
      if (addr_we) addr_r <= addr_wd;
    end
  end

  assign cfg_q = cfg_r;

  // Granularity view: the stored bits are kept, the mask is applied on read.
  always_comb begin
    if (cfg_r.mode == MODE_NAPOT) addr_rd = addr_r | ONES_MASK;
    else                          addr_rd = addr_r & ~ZERO_MASK;
  end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_bank_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          NUM_ENTRIES = 16,
  parameter int          GRAN        = 2,
  parameter bit          TRAP_ABSENT = 1'b1,
  parameter logic [7:0]  RST_CFG     = 8'h00,
  parameter logic [63:0] RST_ADDR    = 64'h0,
  localparam int         NE          = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1,
  localparam int         ADDR_W      = (XLEN == 64) ? 54 : 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [11:0]        req_csr,
  input  logic [XLEN-1:0]    req_wdata,
  input  logic [1:0]         req_priv,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [XLEN-1:0]    rsp_rdata,
  output logic               rsp_illegal,
  output logic [NE*8-1:0]    pmp_cfg_o,
  output logic [NE*ADDR_W-1:0] pmp_addr_o
);
  localparam int BYTES = XLEN / 8;

  logic              dec_cfg, dec_addr, dec_present;
  logic [5:0]        dec_idx;
  logic              accept, m_mode, wr_ok, illegal_now;
  logic [XLEN-1:0]   rd_raw, rd_final;
  logic [7:0]        cfg_q   [64];
  logic [ADDR_W-1:0] addr_rd [64];

  pmp_csr_decode #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .csr     (req_csr),
    .is_cfg  (dec_cfg),
    .is_addr (dec_addr),
    .idx     (dec_idx),
    .present (dec_present)
  );

  assign req_ready   = !rsp_valid || rsp_ready;
  assign accept      = req_valid && req_ready;
  assign m_mode      = (req_priv == 2'b11);
  assign wr_ok       = accept && req_write && m_mode && dec_present;
  assign illegal_now = !m_mode || (!dec_present && TRAP_ABSENT);

  for (genvar i = 0; i < 64; i++) begin : g_slot
    if (i < NUM_ENTRIES) begin : g_live
      logic we_c, we_a;
      assign we_c = wr_ok && dec_cfg && (int'(dec_idx) * 4 <= i) && (i < int'(dec_idx) * 4 + BYTES);
      assign we_a = wr_ok && dec_addr && (dec_idx == 6'(i));
      pmp_entry #(
        .ADDR_W (ADDR_W), .GRAN (GRAN), .RST_CFG (RST_CFG), .RST_ADDR (RST_ADDR)
      ) u_ent (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (we_c),
        .cfg_wd  (req_wdata[8*(i%BYTES) +: 8]),
        .addr_we (we_a),
        .addr_wd (req_wdata[ADDR_W-1:0]),
        .cfg_q   (cfg_q[i]),
        .addr_rd (addr_rd[i])
      );
    end else begin : g_idle
      assign cfg_q[i]   = '0;
      assign addr_rd[i] = '0;
    end
  end

  for (genvar i = 0; i < NE; i++) begin : g_out
    assign pmp_cfg_o[8*i +: 8]           = cfg_q[i];
    assign pmp_addr_o[ADDR_W*i +: ADDR_W] = addr_rd[i];
  end

  always_comb begin
    logic [7:0] ent;
    ent    = '0;
    rd_raw = '0;
    if (dec_cfg) begin
      for (int k = 0; k < BYTES; k++) begin
        ent = {dec_idx, 2'b00} + 8'(k);
        if (int'(ent) < NUM_ENTRIES) rd_raw[8*k +: 8] = cfg_q[ent[5:0]];
      end
    end else if (dec_addr && int'(dec_idx) < NUM_ENTRIES) begin
      rd_raw[ADDR_W-1:0] = addr_rd[dec_idx];
    end
    rd_final = (dec_present && m_mode) ? rd_raw : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_rdata   <= rd_final;
      rsp_illegal <= illegal_now;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int GRAN        = 2,
  localparam int NE         = (NUM_ENTRIES > 0) ? NUM_ENTRIES : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_priv,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [XLEN-1:0] rsp_rdata,
  input logic            rsp_illegal,
  input logic [NE*8-1:0] pmp_cfg_o
);
  logic rsvd_seen, na4_seen;

  always_comb begin
    rsvd_seen = 1'b0;
    na4_seen  = 1'b0;
    for (int i = 0; i < NE; i++) begin
      rsvd_seen = rsvd_seen | (|pmp_cfg_o[8*i+5 +: 2]);
      na4_seen  = na4_seen | (pmp_cfg_o[8*i+3 +: 2] == 2'd2);
    end
  end

  // R1
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_illegal)));

  // R2
  low_priv_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_priv != 2'b11) |=> (rsp_illegal && rsp_rdata == '0));

  // R4
  illegal_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (rsp_rdata == '0));

  // R7
  cfg_rsvd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsvd_seen);

  // R7
  cfg_no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GRAN > 2) |-> !na4_seen);

endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(
  .XLEN (XLEN), .NUM_ENTRIES (NUM_ENTRIES), .GRAN (GRAN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_priv    (req_priv),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_illegal (rsp_illegal),
  .pmp_cfg_o   (pmp_cfg_o)
);

// File: tb/pmp_csr_bank_bench.sv
module pmp_csr_bank_bench;
  localparam int CLK_PERIOD = 10;

  // Instance 0: XLEN 32, 5 entries, GRAN 4, trapping. Instance 1: XLEN 64, 20 entries, GRAN 2, not trapping.
  localparam int N0 = 5,  X0 = 32, GR0 = 4;
  localparam int N1 = 20, X1 = 64, GR1 = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic va = 1'b0, vb = 1'b0;
  logic req_write = 1'b0;
  logic [11:0] req_csr = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_priv = 2'b11;
  logic rsp_ready = 1'b1;

  logic rdy_a, rdy_b, rv_a, rv_b, ill_a, ill_b;
  logic [31:0] rd_a;
  logic [63:0] rd_b;
  logic [N0*8-1:0]  cfg_a;
  logic [N0*32-1:0] adr_a;
  logic [N1*8-1:0]  cfg_b;
  logic [N1*54-1:0] adr_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0]  mcfg  [2][64];
  logic [63:0] maddr [2][64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_csr_bank #(.XLEN(X0), .NUM_ENTRIES(N0), .GRAN(GR0), .TRAP_ABSENT(1'b1)) u_pmp_csr_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(rdy_a), .req_write(req_write),
    .req_csr(req_csr), .req_wdata(req_wdata[31:0]), .req_priv(req_priv),
    .rsp_valid(rv_a), .rsp_ready(rsp_ready), .rsp_rdata(rd_a), .rsp_illegal(ill_a),
    .pmp_cfg_o(cfg_a), .pmp_addr_o(adr_a));

  pmp_csr_bank #(.XLEN(X1), .NUM_ENTRIES(N1), .GRAN(GR1), .TRAP_ABSENT(1'b0)) u_pmp_csr_bank_b (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rdy_b), .req_write(req_write),
    .req_csr(req_csr), .req_wdata(req_wdata), .req_priv(req_priv),
    .rsp_valid(rv_b), .rsp_ready(rsp_ready), .rsp_rdata(rd_b), .rsp_illegal(ill_b),
    .pmp_cfg_o(cfg_b), .pmp_addr_o(adr_b));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int p_n(int s);  return s == 0 ? N0 : N1;   endfunction
  function automatic int p_x(int s);  return s == 0 ? X0 : X1;   endfunction
  function automatic int p_gr(int s); return s == 0 ? GR0 : GR1; endfunction
  function automatic bit p_tr(int s); return s == 0;             endfunction

  function automatic logic [7:0] m_legal(int s, logic [7:0] b);
    logic [7:0] r = b;
    r[6:5] = 2'b00;
    if (r[1] && !r[0]) r[1] = 1'b0;
    if (p_gr(s) > 2 && r[4:3] == 2'd2) r[4:3] = 2'd0;
    return r;
  endfunction

  function automatic logic [63:0] m_view(int s, int e);
    int g = p_gr(s) - 2;
    logic [63:0] a = maddr[s][e];
    if (mcfg[s][e][4:3] == 2'd3) begin
      if (g >= 2) a = a | ((64'd1 << (g - 1)) - 64'd1);
    end else if (g >= 1) begin
      a = a & ~((64'd1 << g) - 64'd1);
    end
    return a;
  endfunction

  // Model of one machine-mode access: data, illegal flag, requirement tag.
  task automatic m_read(input int s, input logic [11:0] csr, output logic [63:0] d,
                        output bit ill, output bit pres, output string tag);
    int n = p_n(s);
    int vis = (n == 0) ? 0 : ((n <= 16) ? 16 : 64);
    d = '0; pres = 0; tag = "R3,R4";
    if (csr >= 12'h3A0 && csr <= 12'h3AF) begin
      int c = int'(csr) - 'h3A0;
      pres = (c < vis / 4) && (p_x(s) == 32 || c % 2 == 0);
      if (pres) begin
        tag = (4 * c >= n) ? "R5" : "R6";
        for (int k = 0; k < p_x(s) / 8; k++)
          if (4 * c + k < n) d[8*k +: 8] = mcfg[s][4*c+k];
      end
    end else if (csr >= 12'h3B0 && csr <= 12'h3EF) begin
      int a = int'(csr) - 'h3B0;
      pres = a < vis;
      if (pres) begin
        tag = (a >= n) ? "R5" : "R8";
        if (a < n) d = m_view(s, a);
      end
    end
    ill = !pres && p_tr(s);
  endtask

  task automatic m_write(input int s, input logic [11:0] csr, input logic [63:0] wd);
    logic [63:0] d; bit ill, pres; string tag;
    int n = p_n(s);
    m_read(s, csr, d, ill, pres, tag);
    if (!pres) return;
    if (csr <= 12'h3AF) begin
      int c = int'(csr) - 'h3A0;
      for (int k = 0; k < p_x(s) / 8; k++)
        if (4 * c + k < n) mcfg[s][4*c+k] = m_legal(s, wd[8*k +: 8]);
    end else begin
      int a = int'(csr) - 'h3B0;
      if (a < n) maddr[s][a] = (p_x(s) == 64) ? (wd & ((64'd1 << 54) - 1)) : {32'd0, wd[31:0]};
    end
  endtask

  task automatic do_req(input int s, input bit wr, input logic [11:0] csr, input logic [63:0] wd,
                        input logic [1:0] priv, output logic [63:0] rd, output bit ill);
    @(negedge clk);
    req_write = wr; req_csr = csr; req_wdata = wd; req_priv = priv;
    if (s == 0) va = 1'b1; else vb = 1'b1;
    @(negedge clk);
    va = 1'b0; vb = 1'b0;
    rd  = (s == 0) ? {32'd0, rd_a} : rd_b;
    ill = (s == 0) ? ill_a : ill_b;
    chk((s == 0) ? rv_a : rv_b, "R1 response one cycle after accept", 64'd0, 64'd1);
  endtask

  task automatic sweep_read(input int s);
    logic [63:0] rd, ed; bit ill, eill, pres; string tag;
    for (int csr = 'h39E; csr <= 'h3F1; csr++) begin
      do_req(s, 1'b0, 12'(csr), 64'd0, 2'b11, rd, ill);
      m_read(s, 12'(csr), ed, eill, pres, tag);
      chk(rd == ed, tag, rd, ed);
      chk(ill == eill, {tag, " illegal flag"}, 64'(ill), 64'(eill));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [63:0] rd, ed; bit ill, eill, pres; string tag;
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 64; e++) begin mcfg[s][e] = '0; maddr[s][e] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(cfg_a == '0 && adr_a == '0, "R10 reset outputs inst0", 64'(cfg_a), 64'd0);
    chk(cfg_b == '0 && adr_b == '0, "R10 reset outputs inst1", 64'(cfg_b), 64'd0);
    chk(!rv_a && !rv_b && rdy_a && rdy_b, "R1 idle after reset", {62'd0, rv_a, rv_b}, 64'd0);

    for (int s = 0; s < 2; s++) begin
      sweep_read(s);
      // R9 write sweep: returned value is the old one.
      for (int csr = 'h39E; csr <= 'h3F1; csr++) begin
        logic [63:0] wd;
        wd = {4{csr[3:0], ~csr[7:4], 8'(csr)}};
        m_read(s, 12'(csr), ed, eill, pres, tag);
        do_req(s, 1'b1, 12'(csr), wd, 2'b11, rd, ill);
        chk(rd == ed, "R9 old value on write", rd, ed);
        m_write(s, 12'(csr), wd);
      end
      sweep_read(s);

      // R7 and R8: every configuration byte on entry 0 with a fixed address.
      do_req(s, 1'b1, 12'h3B0, 64'h0000_0000_DEAD_BEE9, 2'b11, rd, ill);
      m_write(s, 12'h3B0, 64'h0000_0000_DEAD_BEE9);
      for (int v = 0; v < 256; v++) begin
        logic [63:0] wd;
        wd = {8{8'(v)}};
        do_req(s, 1'b1, 12'h3A0, wd, 2'b11, rd, ill);
        m_write(s, 12'h3A0, wd);
        if (s == 0) begin
          chk(cfg_a[7:0] == mcfg[0][0], "R10 R7 cfg output entry0", 64'(cfg_a[7:0]), 64'(mcfg[0][0]));
          chk(64'(adr_a[31:0]) == m_view(0, 0), "R10 R8 addr output entry0", 64'(adr_a[31:0]), m_view(0, 0));
        end else begin
          chk(cfg_b[7:0] == mcfg[1][0], "R10 R7 cfg output entry0", 64'(cfg_b[7:0]), 64'(mcfg[1][0]));
          chk(64'(adr_b[53:0]) == m_view(1, 0), "R10 R8 addr output entry0", 64'(adr_b[53:0]), m_view(1, 0));
        end
        do_req(s, 1'b0, 12'h3A0, 64'd0, 2'b11, rd, ill);
        m_read(s, 12'h3A0, ed, eill, pres, tag);
        chk(rd == ed, "R7 cfg read-back", rd, ed);
        do_req(s, 1'b0, 12'h3B0, 64'd0, 2'b11, rd, ill);
        m_read(s, 12'h3B0, ed, eill, pres, tag);
        chk(rd == ed, "R8 addr read-back", rd, ed);
      end

      // R2 lower privileges
      for (int p = 0; p < 3; p++) begin
        do_req(s, 1'b1, 12'h3B1, 64'h1234_5678_9ABC_DEF0, 2'(p), rd, ill);
        chk(ill && rd == 0, "R2 low privilege illegal and zero", {rd[62:0], ill}, 64'd1);
        do_req(s, 1'b0, 12'h3B1, 64'd0, 2'b11, rd, ill);
        m_read(s, 12'h3B1, ed, eill, pres, tag);
        chk(rd == ed, "R2 low privilege write ignored", rd, ed);
      end
    end

    // R1 back-pressure on instance 0
    m_read(0, 12'h3B2, ed, eill, pres, tag);
    @(negedge clk);
    rsp_ready = 1'b0; req_write = 1'b0; req_csr = 12'h3B2; req_priv = 2'b11; va = 1'b1;
    @(negedge clk);
    va = 1'b0;
    chk(rv_a && !rdy_a && 64'(rd_a) == ed, "R1 held response", 64'(rd_a), ed);
    @(negedge clk);
    chk(rv_a && !rdy_a && 64'(rd_a) == ed, "R1 still held", 64'(rd_a), ed);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rv_a && rdy_a, "R1 released", 64'(rv_a), 64'd0);

    summary();
  end

endmodule